// File: doc/BRIEF.md
# MDIO Management Clock and Frame Engine

This block produces the management data clock (MDC) for a PHY management interface by dividing the system bus clock. The divider takes its half-period length directly from a 6-bit speed field. A speed of zero stops the clock and holds it low. A new speed value is adopted only at an MDC edge, so the half-period already in progress always completes at its old length.

On request, the block serialises one read or write management frame on MDIO. The frame is preceded by 32 one bits unless the control word disables that preamble. During a read, the block releases the line for the turnaround and the data bits, and it shifts in the 16 bits the PHY returns.

Software-facing logic writes the control word. A local controller pulses a start strobe together with the frame fields, then waits for `done`.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: The control word holds the speed field in bits 6..1 and the preamble-disable flag in bit 7. All other bits are ignored on write and read back as zero. Reset clears the whole word.
- R2: With a non-zero speed N, each MDC high and low phase lasts exactly N bus clocks. With N=5, the period is 10 bus clocks. After the speed changes from zero to N, the first rising edge comes N+1 clocks after the write takes effect.
- R3: From the second bus clock edge after speed zero is written, MDC is low and stays low.
- R4: A start strobe is ignored while the registered speed is zero, and while a frame is in progress.
- R5: A speed change during operation leaves the current MDC phase at its old length. The new length applies from the next MDC edge onward.
- R6: With bit 7 clear, a frame begins with 32 one bits. With bit 7 set, the frame begins directly with the start pattern 01.
- R7: After the preamble, the frame carries, MSB first: start 01, opcode (01 write, 10 read), 5-bit PHY address, 5-bit register address, a 2-bit turnaround, and 16 data bits. A write frame drives the turnaround as 1 then 0.
- R8: MDIO output values change one bus clock after an MDC rising edge. A read frame drives only the first 14 bits after the preamble. It holds output-enable low for the turnaround and the data bits, and samples the PHY data, MSB first, on the clock at which MDC rises.
- R9: Busy rises the clock after an accepted start. The first bit is driven one clock after the next MDC rising edge. The frame ends one clock after the rising edge that follows the last bit. At that point busy falls and done pulses for one clock. Read data updates only at the done of a read frame and is otherwise stable.
- R10: While idle, MDIO output-enable is low. MDC keeps toggling whenever the speed is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| ctrl_rdata | output | 32 | Control word readback |
| start | input | 1 | Frame start request |
| start_op | input | 2 | Opcode for the frame |
| start_phy | input | 5 | PHY address |
| start_reg | input | 5 | Register address |
| start_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock frame completion pulse |
| rd_data | output | 16 | Data captured by the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the block with its default parameters: a 6-bit speed field, 16-bit data and a 32-bit preamble. It then programs speeds of 1, 2, 3, 5 and 7. Speed 1 places the sample strobe and the drive strobe on adjacent bus clocks. Speeds 3 to 7 make a mid-phase speed change observable as distinct phase lengths. The default 32-bit preamble lets both frame lengths be compared bit for bit against the frame the bench assembles from the fields.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int SPEED_W   = 6;
    localparam int OP_W      = 2;
    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int CTRL_W    = 32;
    localparam int SPD_LSB   = 1;
    localparam int SPD_MSB   = SPD_LSB + SPEED_W - 1;
    localparam int NOPRE_BIT = SPD_MSB + 1;
    localparam int FRAME_W   = 2 + OP_W + PHY_W + REG_W + 2 + DATA_W;
    localparam int SHIFT_W   = PRE_LEN + FRAME_W;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_WRITE = 2'b10;
    localparam logic [1:0] TA_IDLE  = 2'b11;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_WAIT,
        ENG_SHIFT
    } eng_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] wdata;
    } mgmt_req_t;

    function automatic logic [FRAME_W-1:0] pack_frame(input mgmt_req_t r);
        logic rd;
        rd = (r.op == OP_READ);
        return {SOF_BITS, r.op, r.phy, r.regad,
                rd ? TA_IDLE : TA_WRITE,
                rd ? {DATA_W{1'b1}} : r.wdata};
    endfunction

    function automatic logic [SHIFT_W-1:0] pack_word(input mgmt_req_t r, input logic no_pre);
        if (no_pre)
            return {pack_frame(r), {PRE_LEN{1'b1}}};
        return {{PRE_LEN{1'b1}}, pack_frame(r)};
    endfunction

endpackage

// File: rtl/mdio_ctrl_reg.sv
module mdio_ctrl_reg
    import mdio_pkg::*;
#(
    parameter int WORD_W = CTRL_W,
    parameter int SPD_W  = SPEED_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [SPD_W-1:0]  speed,
    output logic              no_pre
);
    localparam int HI = SPD_LSB + SPD_W - 1;
    localparam int NP = HI + 1;

    logic unused_rsvd;
    assign unused_rsvd = ^{wdata[WORD_W-1:NP+1], wdata[SPD_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            speed  <= '0;
            no_pre <= 1'b0;
        end else if (we) begin
            speed  <= wdata[HI:SPD_LSB];
            no_pre <= wdata[NP];
        end
    end

    always_comb begin
        rdata             = '0;
        rdata[HI:SPD_LSB] = speed;
        rdata[NP]         = no_pre;
    end
endmodule

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SPD_W-1:0] speed,
    output logic             mdc,
    output logic             sample_tick,
    output logic             drive_tick
);
    logic [SPD_W-1:0] half_q;
    logic [SPD_W-1:0] phase_q;
    logic             mdc_q;
    logic             rose_q;
    logic             at_end;

    assign at_end      = (half_q != '0) && (phase_q == half_q - 1'b1);
    assign sample_tick = (speed != '0) && at_end && !mdc_q;
    assign mdc         = mdc_q;
    assign drive_tick  = rose_q;

    always_ff @(posedge clk) begin
        if (rst || speed == '0) begin
            half_q  <= '0;
            phase_q <= '0;
            mdc_q   <= 1'b0;
            rose_q  <= 1'b0;
        end else begin
            rose_q <= sample_tick;
            if (half_q == '0) begin
                half_q  <= speed;
                phase_q <= '0;
            end else if (at_end) begin
                mdc_q   <= ~mdc_q;
                phase_q <= '0;
                half_q  <= speed;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int DWIDTH = DATA_W,
    parameter int FWIDTH = FRAME_W,
    parameter int SWIDTH = SHIFT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              no_pre,
    input  logic              start,
    input  mgmt_req_t         req,
    input  logic              sample_tick,
    input  logic              drive_tick,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              busy,
    output logic              done,
    output logic [DWIDTH-1:0] rd_data
);
    localparam int CNT_W  = $clog2(SWIDTH + 1);
    localparam int REL_AT = DWIDTH + 2;

    eng_state_e        state_q;
    logic [SWIDTH-1:0] sh_q;
    logic [CNT_W-1:0]  rem_q;
    logic [CNT_W-1:0]  len_q;
    logic              rd_mode_q;
    logic              oe_q;
    logic              done_q;
    logic [DWIDTH-1:0] cap_q;
    logic [DWIDTH-1:0] rd_q;

    assign mdio_o  = sh_q[SWIDTH-1];
    assign mdio_oe = oe_q;
    assign busy    = (state_q != ENG_IDLE);
    assign done    = done_q;
    assign rd_data = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ENG_IDLE;
            sh_q      <= '1;
            rem_q     <= '0;
            len_q     <= '0;
            rd_mode_q <= 1'b0;
            oe_q      <= 1'b0;
            done_q    <= 1'b0;
            cap_q     <= '0;
            rd_q      <= '0;
        end else begin
            done_q <= 1'b0;
            if (sample_tick && state_q == ENG_SHIFT && rd_mode_q
                && rem_q <= CNT_W'(DWIDTH))
                cap_q <= {cap_q[DWIDTH-2:0], mdio_i};
            case (state_q)
                ENG_IDLE: begin
                    if (start && enable) begin
                        state_q   <= ENG_WAIT;
                        sh_q      <= pack_word(req, no_pre);
                        len_q     <= no_pre ? CNT_W'(FWIDTH) : CNT_W'(SWIDTH);
                        rd_mode_q <= (req.op == OP_READ);
                    end
                end
                ENG_WAIT: begin
                    if (drive_tick) begin
                        state_q <= ENG_SHIFT;
                        rem_q   <= len_q;
                        oe_q    <= 1'b1;
                    end
                end
                ENG_SHIFT: begin
                    if (drive_tick) begin
                        if (rem_q == CNT_W'(1)) begin
                            state_q <= ENG_IDLE;
                            oe_q    <= 1'b0;
                            done_q  <= 1'b1;
                            if (rd_mode_q)
                                rd_q <= cap_q;
                        end else begin
                            sh_q  <= {sh_q[SWIDTH-2:0], 1'b1};
                            rem_q <= rem_q - 1'b1;
                            oe_q  <= !(rd_mode_q && (rem_q - 1'b1) <= CNT_W'(REL_AT));
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_pkg::*;
#(
    parameter int SPD_W  = SPEED_W,
    parameter int DWIDTH = DATA_W,
    parameter int WORD_W = CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [WORD_W-1:0] ctrl_wdata,
    output logic [WORD_W-1:0] ctrl_rdata,
    input  logic              start,
    input  logic [OP_W-1:0]   start_op,
    input  logic [PHY_W-1:0]  start_phy,
    input  logic [REG_W-1:0]  start_reg,
    input  logic [DWIDTH-1:0] start_wdata,
    output logic              busy,
    output logic              done,
    output logic [DWIDTH-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [SPD_W-1:0] speed;
    logic             no_pre;
    logic             sample_tick;
    logic             drive_tick;
    mgmt_req_t        req;

    assign req = '{op: start_op, phy: start_phy, regad: start_reg, wdata: start_wdata};

    mdio_ctrl_reg #(.WORD_W(WORD_W), .SPD_W(SPD_W)) u_ctrl (
        .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata),
        .rdata(ctrl_rdata), .speed(speed), .no_pre(no_pre)
    );

    mdc_divider #(.SPD_W(SPD_W)) u_div (
        .clk(clk), .rst(rst), .speed(speed), .mdc(mdc),
        .sample_tick(sample_tick), .drive_tick(drive_tick)
    );

    mdio_frame_engine #(.DWIDTH(DWIDTH)) u_eng (
        .clk(clk), .rst(rst), .enable(speed != '0), .no_pre(no_pre),
        .start(start), .req(req), .sample_tick(sample_tick),
        .drive_tick(drive_tick), .mdio_i(mdio_i), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .busy(busy), .done(done), .rd_data(rd_data)
    );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
    parameter int SPD_W  = 6,
    parameter int DWIDTH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [SPD_W-1:0]  speed,
    input logic              start,
    input logic              mdc,
    input logic              busy,
    input logic              done,
    input logic              mdio_oe,
    input logic [DWIDTH-1:0] rd_data
);
    assert_mdc_parked_R3: assert property (@(posedge clk) disable iff (rst)
        (speed == '0) |=> !mdc);

    assert_start_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (start && speed == '0 && !busy) |=> !busy);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_rd_only_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> done);

    assert_oe_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);
endmodule

bind mdio_mgmt_engine mdio_mgmt_checker #(.SPD_W(SPD_W), .DWIDTH(DWIDTH)) u_chk (
    .clk(clk), .rst(rst), .speed(speed), .start(start), .mdc(mdc),
    .busy(busy), .done(done), .mdio_oe(mdio_oe), .rd_data(rd_data)
);

// File: tb/mdio_mgmt_engine_test.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        start = 1'b0;
    logic [1:0]  start_op = '0;
    logic [4:0]  start_phy = '0;
    logic [4:0]  start_reg = '0;
    logic [15:0] start_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    always #10 clk = ~clk;

    mdio_mgmt_engine uut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .start(start), .start_op(start_op),
        .start_phy(start_phy), .start_reg(start_reg), .start_wdata(start_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int nvec = 0;
    int nbad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference model, evaluated at each rising clock edge
    int  e_spd, e_ph, e_hl, e_state, e_rem, e_len, o_spd;
    bit  e_pre, e_mdc, e_rose, e_busy, e_done, e_oe, e_o, e_read;
    bit  o_pre, o_rose, rise;
    logic [15:0] e_cap, e_rd, resp;
    bit  eq[$];

    always @(posedge clk) begin
        if (rst) begin
            e_spd = 0; e_pre = 0; e_mdc = 0; e_ph = 0; e_hl = 0; e_rose = 0;
            e_state = 0; e_busy = 0; e_done = 0; e_oe = 0; e_o = 1; e_rem = 0;
            e_len = 0; e_read = 0; e_cap = 0; e_rd = 0; eq.delete();
        end else begin
            o_spd = e_spd; o_pre = e_pre; o_rose = e_rose; rise = 0; e_done = 0;
            if (o_spd == 0) begin
                e_mdc = 0; e_ph = 0; e_hl = 0;
            end else if (e_hl == 0) begin
                e_hl = o_spd; e_ph = 0;
            end else if (e_ph == e_hl - 1) begin
                rise = !e_mdc; e_mdc = !e_mdc; e_ph = 0; e_hl = o_spd;
            end else begin
                e_ph++;
            end
            if (rise && e_state == 2 && e_read && e_rem <= 16)
                e_cap = {e_cap[14:0], mdio_i};
            if (e_state == 0) begin
                if (start && o_spd != 0) begin
                    eq.delete();
                    e_read = (start_op == 2'b10);
                    if (!o_pre) for (int i = 0; i < 32; i++) eq.push_back(1'b1);
                    eq.push_back(1'b0); eq.push_back(1'b1);
                    for (int i = 1; i >= 0; i--) eq.push_back(start_op[i]);
                    for (int i = 4; i >= 0; i--) eq.push_back(start_phy[i]);
                    for (int i = 4; i >= 0; i--) eq.push_back(start_reg[i]);
                    eq.push_back(1'b1); eq.push_back(e_read);
                    for (int i = 15; i >= 0; i--) eq.push_back(e_read ? 1'b1 : start_wdata[i]);
                    e_len = eq.size(); e_state = 1; e_busy = 1;
                end
            end else if (e_state == 1) begin
                if (o_rose) begin
                    e_o = eq.pop_front(); e_rem = e_len; e_oe = 1; e_state = 2;
                end
            end else begin
                if (o_rose) begin
                    if (e_rem == 1) begin
                        e_state = 0; e_busy = 0; e_done = 1; e_oe = 0;
                        if (e_read) e_rd = e_cap;
                    end else begin
                        e_o = eq.pop_front(); e_rem--;
                        e_oe = !(e_read && e_rem <= 18);
                    end
                end
            end
            e_rose = rise;
            if (ctrl_we) begin
                e_spd = int'(ctrl_wdata[6:1]); e_pre = ctrl_wdata[7];
            end
        end
    end

    // per-cycle comparison, PHY responder and bit collector
    bit          mdc_prev = 0;
    logic [63:0] coll;
    int          ncoll;

    always @(negedge clk) begin
        if (!rst) begin
            chk(mdc === e_mdc, e_spd != 0 ? "R2 mdc" : "R3 mdc", mdc, e_mdc);
            chk(mdio_oe === e_oe, "R8 mdio_oe", mdio_oe, e_oe);
            if (e_oe) chk(mdio_o === e_o, "R7 mdio_o", mdio_o, e_o);
            chk(busy === e_busy, "R9 busy", busy, e_busy);
            chk(done === e_done, "R9 done", done, e_done);
            chk(rd_data === e_rd, "R9 rd_data", rd_data, e_rd);
            if (mdc && !mdc_prev && mdio_oe) begin
                coll = {coll[62:0], mdio_o};
                ncoll++;
            end
        end
        mdc_prev = mdc;
        if (e_state == 2 && e_read && e_rem >= 1 && e_rem <= 16)
            mdio_i = resp[e_rem-1];
        else
            mdio_i = 1'b1;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            nbad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic kick(input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] ra, input logic [15:0] wd);
        start = 1'b1; start_op = op; start_phy = phy; start_reg = ra; start_wdata = wd;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_rise();
        bit p, seen;
        p = mdc; seen = 0;
        while (!seen) begin
            @(negedge clk);
            seen = mdc && !p;
            p = mdc;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 20000);
    endtask

    int hi, lo;

    initial begin
        resp = 16'h3C96;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ctrl_rdata == 32'h0, "R1 reset word", ctrl_rdata, 0);
        chk(!mdc && !mdio_oe && !busy, "R10 reset idle", {mdc, mdio_oe, busy}, 0);

        wr_ctrl(32'hFFFF_FF01);
        chk(ctrl_rdata == 32'h0, "R1 reserved ignored", ctrl_rdata, 0);
        wr_ctrl(32'hFFFF_FFFF);
        chk(ctrl_rdata == 32'h0000_00FE, "R1 field layout", ctrl_rdata, 32'hFE);
        wr_ctrl(32'h0);

        kick(2'b01, 5'h01, 5'h02, 16'h1234);
        repeat (10) @(negedge clk);
        chk(!busy, "R4 start at speed zero", busy, 0);
        chk(!mdc, "R3 mdc parked", mdc, 0);

        wr_ctrl(32'h0000_000A);
        wait_rise();
        hi = 0; while (mdc) begin hi++; @(negedge clk); end
        lo = 0; while (!mdc) begin lo++; @(negedge clk); end
        chk(hi == 5, "R2 high phase", hi, 5);
        chk(lo == 5, "R2 low phase", lo, 5);
        chk(hi + lo == 10, "R2 period", hi + lo, 10);

        coll = '0; ncoll = 0;
        kick(2'b01, 5'h11, 5'h05, 16'hA5C3);
        repeat (40) @(negedge clk);
        kick(2'b10, 5'h1F, 5'h1F, 16'h0000);
        wait_idle();
        @(negedge clk);
        chk(ncoll == 64, "R6 preamble frame length", ncoll, 64);
        chk(coll == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h05, 2'b10, 16'hA5C3},
            "R7 write frame bits", coll,
            {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h05, 2'b10, 16'hA5C3});
        chk(!mdio_oe, "R10 released after frame", mdio_oe, 0);

        wr_ctrl(32'h0000_0082);
        coll = '0; ncoll = 0;
        kick(2'b10, 5'h03, 5'h1F, 16'h0000);
        wait_idle();
        @(negedge clk);
        chk(rd_data == 16'h3C96, "R9 read data", rd_data, 16'h3C96);
        chk(ncoll == 14, "R8 driven bits in read", ncoll, 14);
        chk(coll[13:0] == {2'b01, 2'b10, 5'h03, 5'h1F}, "R6 no preamble read header",
            coll[13:0], {2'b01, 2'b10, 5'h03, 5'h1F});

        wr_ctrl(32'h0000_0084);
        coll = '0; ncoll = 0;
        kick(2'b01, 5'h0A, 5'h15, 16'h0F0F);
        wait_idle();
        @(negedge clk);
        chk(ncoll == 32, "R6 no preamble write length", ncoll, 32);
        chk(rd_data == 16'h3C96, "R9 write keeps rd_data", rd_data, 16'h3C96);

        wr_ctrl(32'h0000_0006);
        repeat (12) @(negedge clk);
        wait_rise();
        hi = 1;
        wr_ctrl(32'h0000_000E);
        while (mdc) begin hi++; @(negedge clk); end
        lo = 0; while (!mdc) begin lo++; @(negedge clk); end
        chk(hi == 3, "R5 old phase completes", hi, 3);
        chk(lo == 7, "R5 new phase length", lo, 7);

        wr_ctrl(32'h0);
        @(negedge clk);
        chk(!mdc, "R3 stop after write", mdc, 0);
        repeat (20) @(negedge clk);
        chk(!mdc, "R3 stays low", mdc, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule